// File: doc/BRIEF.md
# Banked Cartridge Mapper with Reloadable Cycle Timer

This block sits between a CPU and the program and character memories of a cartridge. It translates CPU program addresses and video character addresses into wider memory addresses. It also raises an interrupt after a programmed number of CPU cycles. The CPU space from 0x8000 to 0xFFFF is seen as four 8 KB windows. The software selects the bank for each of the first three windows. The top window always maps to the last bank. The character space is split into eight 1 KB slots, and each slot has its own bank register. One register bit selects the nametable mirroring.

All control happens through CPU writes into the program space. Each register is decoded at one exact offset, and a write at any other offset does nothing. The timer counts down once per CPU cycle. It is loaded from a 16-bit reload value that software writes as two separate bytes. When the count reaches zero, the interrupt is latched. It stays set until software acknowledges it, either by writing the control register or by issuing a reload. The block's clock runs at one tick per CPU cycle.

Top module: `irq_bank_mapper`

## Requirements
- R1: After reset, every bank register is 0, mirroring is vertical (`mirror_horz`=0), the timer is disabled with a count of 0 and a reload value of 0, and `irq` is 0.
- R2: Writes at offsets 0x0000, 0x2000 and 0x4000 set the banks for windows 0, 1 and 2. The window is `cpu_addr[14:13]`. `prg_addr` = {bank of the window, `cpu_addr[12:0]`}. Bank registers keep the low PRG_BANK_W bits of the data.
- R3: Window 3 (`cpu_addr[14:13]`=3) always maps to the last bank: every bank bit of `prg_addr` is 1.
- R4: A write at offset 0x1001 sets `mirror_horz` to data bit 7. Between such writes the output holds.
- R5: A write at offset 0x3000+n (n = 0..7) sets character bank n. `chr_addr` = {bank[`ppu_addr[12:10]`], `ppu_addr[9:0]`}.
- R6: Offset 0x1005 writes the high byte of the reload value and offset 0x1006 writes the low byte. A write at offset 0x1004 copies the reload value, as it stood before that edge, into the counter and clears `irq`.
- R7: A write at offset 0x1003 sets the timer enable from data bit 7 and clears `irq`.
- R8: While enabled and nonzero, the counter drops by one every cycle. While disabled, it holds its value.
- R9: `irq` rises on the edge where an enabled count steps from 1 to 0. The count then stays at 0, and `irq` stays at 1 until acknowledged. Reloading a value of 0 never raises `irq`.
- R10: In a cycle that carries a 0x1003 or 0x1004 write, the write takes precedence. The acknowledge beats an expiry in that same cycle, and the reload beats the decrement.
- R11: Writes at any other offset (for example 0x0001, 0x1000, 0x1002, 0x1007, 0x3008, 0x6000) change no output and no timer state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | CPU cycle clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | CPU write strobe into program space |
| wr_addr | input | 15 | Write offset from 0x8000 |
| wr_data | input | 8 | Write data |
| cpu_addr | input | 15 | CPU read offset from 0x8000 |
| ppu_addr | input | 13 | Video character address |
| prg_addr | output | PRG_BANK_W+13 | Translated program memory address |
| chr_addr | output | CHR_BANK_W+10 | Translated character memory address |
| mirror_horz | output | 1 | 1 = horizontal mirroring, 0 = vertical |
| irq | output | 1 | Active-high timer interrupt |

## Verification
The bench builds the block with PRG_BANK_W=6, CHR_BANK_W=8 and COUNT_W=16. With a 6-bit program bank, random data bytes exercise the truncation of the upper data bits and let the fixed top bank be told apart from a written one. The full 16-bit timer is kept. Random reload values use mostly small high bytes so that expiry happens often, and directed runs pin the exact expiry cycle. They also cover a reload of zero, and an acknowledge or reload that lands on the expiry cycle itself.

// File: rtl/irqmap_pkg.sv
`timescale 1ns/1ps
package irqmap_pkg;
    // One strobe per register that a CPU write may touch
    typedef struct packed {
        logic       prg0;
        logic       prg1;
        logic       prg2;
        logic       mirror;
        logic       tmr_ctl;
        logic       reload;
        logic       lat_hi;
        logic       lat_lo;
        logic       chr;
        logic [2:0] chr_idx;
    } wr_dec_t;

    localparam logic [14:0] OFS_PRG0   = 15'h0000;
    localparam logic [14:0] OFS_PRG1   = 15'h2000;
    localparam logic [14:0] OFS_PRG2   = 15'h4000;
    localparam logic [14:0] OFS_MIRROR = 15'h1001;
    localparam logic [14:0] OFS_TMRCTL = 15'h1003;
    localparam logic [14:0] OFS_RELOAD = 15'h1004;
    localparam logic [14:0] OFS_LATHI  = 15'h1005;
    localparam logic [14:0] OFS_LATLO  = 15'h1006;
    localparam logic [11:0] OFS_CHR_HI = 12'h600; // 0x3000 >> 3
endpackage

// File: rtl/irqmap_decode.sv
`timescale 1ns/1ps
module irqmap_decode
    import irqmap_pkg::*;
(
    input  logic        wr_en,
    input  logic [14:0] wr_addr,
    output wr_dec_t     dec
);
    always_comb begin
        dec         = '0;
        dec.prg0    = wr_en && (wr_addr == OFS_PRG0);
        dec.prg1    = wr_en && (wr_addr == OFS_PRG1);
        dec.prg2    = wr_en && (wr_addr == OFS_PRG2);
        dec.mirror  = wr_en && (wr_addr == OFS_MIRROR);
        dec.tmr_ctl = wr_en && (wr_addr == OFS_TMRCTL);
        dec.reload  = wr_en && (wr_addr == OFS_RELOAD);
        dec.lat_hi  = wr_en && (wr_addr == OFS_LATHI);
        dec.lat_lo  = wr_en && (wr_addr == OFS_LATLO);
        dec.chr     = wr_en && (wr_addr[14:3] == OFS_CHR_HI);
        dec.chr_idx = wr_addr[2:0];
    end
endmodule

// File: rtl/irqmap_banks.sv
`timescale 1ns/1ps
module irqmap_banks
    import irqmap_pkg::*;
#(
    parameter int PRG_BANK_W = 8,
    parameter int CHR_BANK_W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  wr_dec_t                  dec,
    input  logic [7:0]               wr_data,
    input  logic [14:0]              cpu_addr,
    input  logic [12:0]              ppu_addr,
    output logic [PRG_BANK_W+12:0]   prg_addr,
    output logic [CHR_BANK_W+9:0]    chr_addr,
    output logic                     mirror_horz
);
    localparam int NUM_PRG = 3;
    localparam int NUM_CHR = 8;

    typedef struct packed {
        logic [NUM_PRG-1:0][PRG_BANK_W-1:0] prg;
        logic [NUM_CHR-1:0][CHR_BANK_W-1:0] chr;
        logic                               mirror;
    } bank_st_t;

    bank_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (dec.prg0)   st_d.prg[0] = PRG_BANK_W'(wr_data);
        if (dec.prg1)   st_d.prg[1] = PRG_BANK_W'(wr_data);
        if (dec.prg2)   st_d.prg[2] = PRG_BANK_W'(wr_data);
        if (dec.mirror) st_d.mirror = wr_data[7];
        for (int i = 0; i < NUM_CHR; i++) begin
            if (dec.chr && (dec.chr_idx == 3'(i))) st_d.chr[i] = CHR_BANK_W'(wr_data);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    logic [PRG_BANK_W-1:0] win_bank;

    always_comb begin
        unique case (cpu_addr[14:13])
            2'd0:    win_bank = st_q.prg[0];
            2'd1:    win_bank = st_q.prg[1];
            2'd2:    win_bank = st_q.prg[2];
            default: win_bank = '1;
        endcase
    end

    assign prg_addr    = {win_bank, cpu_addr[12:0]};
    assign chr_addr    = {st_q.chr[ppu_addr[12:10]], ppu_addr[9:0]};
    assign mirror_horz = st_q.mirror;
endmodule

// File: rtl/irqmap_timer.sv
`timescale 1ns/1ps
module irqmap_timer
    import irqmap_pkg::*;
#(
    parameter int COUNT_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  wr_dec_t            dec,
    input  logic [7:0]         wr_data,
    output logic               irq,
    output logic [COUNT_W-1:0] count,
    output logic               enable
);
    localparam int HI_W = COUNT_W - 8;

    typedef struct packed {
        logic [COUNT_W-1:0] latch;
        logic [COUNT_W-1:0] count;
        logic               en;
        logic               irq;
    } tmr_st_t;

    tmr_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (dec.lat_hi) st_d.latch[COUNT_W-1:8] = wr_data[HI_W-1:0];
        if (dec.lat_lo) st_d.latch[7:0]         = wr_data;
        // countdown, then the writes take precedence over it
        if (st_q.en && (st_q.count != '0)) begin
            st_d.count = st_q.count - 1'b1;
            if (st_q.count == COUNT_W'(1)) st_d.irq = 1'b1;
        end
        if (dec.reload) begin
            st_d.count = st_q.latch;
            st_d.irq   = 1'b0;
        end
        if (dec.tmr_ctl) begin
            st_d.en  = wr_data[7];
            st_d.irq = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign irq    = st_q.irq;
    assign count  = st_q.count;
    assign enable = st_q.en;
endmodule

// File: rtl/irq_bank_mapper.sv
`timescale 1ns/1ps
module irq_bank_mapper
    import irqmap_pkg::*;
#(
    parameter int PRG_BANK_W = 8,
    parameter int CHR_BANK_W = 8,
    parameter int COUNT_W    = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [14:0]            wr_addr,
    input  logic [7:0]             wr_data,
    input  logic [14:0]            cpu_addr,
    input  logic [12:0]            ppu_addr,
    output logic [PRG_BANK_W+12:0] prg_addr,
    output logic [CHR_BANK_W+9:0]  chr_addr,
    output logic                   mirror_horz,
    output logic                   irq
);
    wr_dec_t            dec;
    logic [COUNT_W-1:0] tmr_count;
    logic               tmr_en;

    irqmap_decode u_decode (
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .dec     (dec)
    );

    irqmap_banks #(
        .PRG_BANK_W (PRG_BANK_W),
        .CHR_BANK_W (CHR_BANK_W)
    ) u_banks (
        .clk         (clk),
        .rst_n       (rst_n),
        .dec         (dec),
        .wr_data     (wr_data),
        .cpu_addr    (cpu_addr),
        .ppu_addr    (ppu_addr),
        .prg_addr    (prg_addr),
        .chr_addr    (chr_addr),
        .mirror_horz (mirror_horz)
    );

    irqmap_timer #(
        .COUNT_W (COUNT_W)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .dec     (dec),
        .wr_data (wr_data),
        .irq     (irq),
        .count   (tmr_count),
        .enable  (tmr_en)
    );
endmodule

// File: rtl/irqmap_checker.sv
`timescale 1ns/1ps
module irqmap_checker #(
    parameter int PRG_BANK_W = 8,
    parameter int COUNT_W    = 16
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   wr_en,
    input logic [14:0]            wr_addr,
    input logic [7:0]             wr_data,
    input logic [14:0]            cpu_addr,
    input logic [PRG_BANK_W+12:0] prg_addr,
    input logic                   mirror_horz,
    input logic                   irq,
    input logic [COUNT_W-1:0]     tmr_count,
    input logic                   tmr_en
);
    logic wr_ctl, wr_rel, wr_mir;
    assign wr_ctl = wr_en && (wr_addr == 15'h1003);
    assign wr_rel = wr_en && (wr_addr == 15'h1004);
    assign wr_mir = wr_en && (wr_addr == 15'h1001);

    AST_CTL_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ctl |=> (!irq && tmr_en == $past(wr_data[7]))); // R7
    AST_RELOAD_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        wr_rel |=> !irq); // R6
    AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !wr_ctl && !wr_rel) |=> irq); // R9
    AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> (tmr_count == '0 && $past(tmr_count) == COUNT_W'(1))); // R9
    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr_en && tmr_count != '0 && !wr_rel) |=> (tmr_count == $past(tmr_count) - 1'b1)); // R8
    AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!tmr_en && !wr_rel) |=> $stable(tmr_count)); // R8
    AST_TOP_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_addr[14:13] == 2'b11) |-> (&prg_addr[PRG_BANK_W+12:13])); // R3
    AST_MIRROR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_mir |=> $stable(mirror_horz)); // R4
endmodule

bind irq_bank_mapper irqmap_checker #(
    .PRG_BANK_W (PRG_BANK_W),
    .COUNT_W    (COUNT_W)
) i_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data),
    .cpu_addr    (cpu_addr),
    .prg_addr    (prg_addr),
    .mirror_horz (mirror_horz),
    .irq         (irq),
    .tmr_count   (tmr_count),
    .tmr_en      (tmr_en)
);

// File: tb/test_irq_bank_mapper.sv
`timescale 1ns/1ps
module test_irq_bank_mapper;
    localparam int PW = 6;
    localparam int CW = 8;
    localparam int TW = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_en = 1'b0;
    logic [14:0]       wr_addr = '0;
    logic [7:0]        wr_data = '0;
    logic [14:0]       cpu_addr = '0;
    logic [12:0]       ppu_addr = '0;
    logic [PW+12:0]    prg_addr;
    logic [CW+9:0]     chr_addr;
    logic              mirror_horz;
    logic              irq;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    // reference state, from the requirements
    logic [PW-1:0] m_prg [3];
    logic [CW-1:0] m_chr [8];
    logic          m_mir;
    logic [TW-1:0] m_lat, m_cnt;
    logic          m_en, m_irq;
    string         irq_tag = "R9";

    always #2.5 clk = ~clk;

    irq_bank_mapper #(.PRG_BANK_W(PW), .CHR_BANK_W(CW), .COUNT_W(TW)) i_irq_bank_mapper (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .cpu_addr(cpu_addr), .ppu_addr(ppu_addr), .prg_addr(prg_addr),
        .chr_addr(chr_addr), .mirror_horz(mirror_horz), .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [PW+12:0] exp_prg(input logic [14:0] a);
        logic [PW-1:0] b;
        b = (a[14:13] == 2'd3) ? {PW{1'b1}} : m_prg[a[14:13]];
        return {b, a[12:0]};
    endfunction

    task automatic model_reset();
        for (int i = 0; i < 3; i++) m_prg[i] = '0;
        for (int i = 0; i < 8; i++) m_chr[i] = '0;
        m_mir = 0; m_lat = '0; m_cnt = '0; m_en = 0; m_irq = 0;
    endtask

    task automatic model_step(input bit we, input logic [14:0] a, input logic [7:0] d);
        logic [TW-1:0] n_lat, n_cnt;
        logic          n_en, n_irq;
        n_lat = m_lat; n_cnt = m_cnt; n_en = m_en; n_irq = m_irq;
        if (m_en && m_cnt != 0) begin
            n_cnt = m_cnt - 1;
            if (m_cnt == 1) n_irq = 1;
        end
        if (we) begin
            case (a)
                15'h0000: m_prg[0] = d[PW-1:0];
                15'h2000: m_prg[1] = d[PW-1:0];
                15'h4000: m_prg[2] = d[PW-1:0];
                15'h1001: m_mir = d[7];
                15'h1003: begin n_en = d[7]; n_irq = 0; end
                15'h1004: begin n_cnt = m_lat; n_irq = 0; end
                15'h1005: n_lat[15:8] = d;
                15'h1006: n_lat[7:0] = d;
                default: if (a[14:3] == 12'h600) m_chr[a[2:0]] = d;
            endcase
        end
        m_lat = n_lat; m_cnt = n_cnt; m_en = n_en; m_irq = n_irq;
    endtask

    task automatic compare_all(input string tag_other);
        chk((cpu_addr[14:13] == 2'd3) ? "R3" : ((tag_other == "") ? "R2" : tag_other),
            32'(prg_addr), 32'(exp_prg(cpu_addr)));
        chk((tag_other == "") ? "R5" : tag_other, 32'(chr_addr),
            32'({m_chr[ppu_addr[12:10]], ppu_addr[9:0]}));
        chk((tag_other == "") ? "R4" : tag_other, 32'(mirror_horz), 32'(m_mir));
        chk(irq_tag, 32'(irq), 32'(m_irq));
    endtask

    task automatic cycle(input bit we, input logic [14:0] a, input logic [7:0] d, input string tag);
        @(negedge clk);
        wr_en = we; wr_addr = a; wr_data = d;
        cpu_addr = 15'($urandom); ppu_addr = 13'($urandom);
        @(posedge clk);
        model_step(we, a, d);
        #1;
        compare_all(tag);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cycle(0, 15'h0, 8'h0, "");
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [14:0] offs [14];
        void'($urandom(32'h5eed_1234));
        model_reset();
        repeat (3) @(posedge clk);
        // R1: reset values visible at the ports
        for (int w = 0; w < 4; w++) begin
            @(negedge clk); cpu_addr = {2'(w), 13'h0abc}; ppu_addr = 13'(w * 1100);
            #1;
            chk("R1", 32'(prg_addr), 32'(exp_prg(cpu_addr)));
            chk("R1", 32'(chr_addr), 32'({8'h0, ppu_addr[9:0]}));
        end
        chk("R1", 32'(irq), 0);
        chk("R1", 32'(mirror_horz), 0);
        @(negedge clk); rst_n = 1;

        // R1: timer idle after reset, enabling with a zero count raises nothing
        irq_tag = "R1";
        cycle(1, 15'h1003, 8'h80, "R1");
        idle(4);
        irq_tag = "R9";

        // R2 / R5 directed bank writes, upper data bits beyond PW dropped
        cycle(1, 15'h0000, 8'hC5, "R2");
        cycle(1, 15'h2000, 8'h3A, "R2");
        cycle(1, 15'h4000, 8'hFF, "R2");
        for (int i = 0; i < 8; i++) cycle(1, 15'h3000 + 15'(i), 8'(8'h11 * (i + 1)), "R5");
        cycle(1, 15'h1001, 8'h80, "R4");
        idle(8);

        // R6 / R8 / R9: exact expiry after 5 cycles
        cycle(1, 15'h1005, 8'h00, "R6");
        cycle(1, 15'h1006, 8'h05, "R6");
        irq_tag = "R8";
        cycle(1, 15'h1004, 8'h00, "R6");
        for (int i = 1; i <= 5; i++) begin
            cycle(0, 15'h0, 8'h0, "");
            chk("R8", 32'(irq), (i == 5) ? 1 : 0);
        end
        irq_tag = "R9";
        idle(3);
        chk("R9", 32'(irq), 1);
        // R11: writes at undecoded offsets leave irq and banks alone
        irq_tag = "R11";
        offs = '{15'h0001, 15'h1000, 15'h1002, 15'h1007, 15'h3008, 15'h6000, 15'h2001,
                 15'h4001, 15'h1008, 15'h5003, 15'h7fff, 15'h3fff, 15'h0fff, 15'h1103};
        foreach (offs[k]) cycle(1, offs[k], 8'hFF, "R11");
        chk("R11", 32'(irq), 1);
        // R7: acknowledge via control write
        irq_tag = "R7";
        cycle(1, 15'h1003, 8'h80, "R7");
        chk("R7", 32'(irq), 0);
        idle(2);

        // R9: reloading zero never raises irq
        irq_tag = "R9";
        cycle(1, 15'h1006, 8'h00, "R9");
        cycle(1, 15'h1004, 8'h00, "R9");
        idle(4);
        chk("R9", 32'(irq), 0);

        // R8: disabled counter holds; re-enable resumes
        cycle(1, 15'h1006, 8'h03, "R8");
        cycle(1, 15'h1004, 8'h00, "R8");
        cycle(1, 15'h1003, 8'h00, "R8");
        idle(10);
        chk("R8", 32'(irq), 0);
        cycle(1, 15'h1003, 8'h80, "R8");
        idle(3);
        chk("R8", 32'(irq), 1);

        // R10: acknowledge on the expiry cycle wins
        irq_tag = "R10";
        cycle(1, 15'h1006, 8'h02, "R10");
        cycle(1, 15'h1004, 8'h00, "R10");
        cycle(0, 15'h0, 8'h0, "R10");
        cycle(1, 15'h1003, 8'h80, "R10");
        chk("R10", 32'(irq), 0);
        // R10: reload on the expiry cycle wins over the decrement
        cycle(1, 15'h1004, 8'h00, "R10");
        cycle(0, 15'h0, 8'h0, "R10");
        cycle(1, 15'h1004, 8'h00, "R10");
        chk("R10", 32'(irq), 0);
        idle(2);
        chk("R10", 32'(irq), 1);
        irq_tag = "R9";

        // longer count: 0x0123 cycles
        cycle(1, 15'h1005, 8'h01, "R6");
        cycle(1, 15'h1006, 8'h23, "R6");
        cycle(1, 15'h1004, 8'h00, "R6");
        idle(300);

        // constrained random mix
        for (int n = 0; n < 6000; n++) begin
            int unsigned pick;
            logic [14:0] a;
            logic [7:0]  d;
            pick = $urandom_range(0, 19);
            d = 8'($urandom);
            case (pick)
                0: a = 15'h0000;
                1: a = 15'h2000;
                2: a = 15'h4000;
                3: a = 15'h1001;
                4: a = 15'h1003;
                5: a = 15'h1004;
                6: begin a = 15'h1005; d = 8'($urandom_range(0, 1)); end
                7: a = 15'h1006;
                8, 9: a = 15'h3000 + 15'($urandom_range(0, 7));
                10: a = 15'($urandom);
                default: a = 15'h0;
            endcase
            cycle(pick <= 10, a, d, "");
        end

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule